// File: doc/BRIEF.md
# Configuration Address Select Decoder

This block sits behind a host bridge's configuration-address register. It turns a 32-bit configuration address into a single-level configuration target. The upper address bits act as select lines, one per device. The decoder reports which device is addressed, the function and register fields, a fixed bus number of zero and a first-level cycle marker. It also reports whether the select pattern is legal.

The decoding logic is combinational. Its result is captured into output registers on each clock edge where the access strobe is high. Between strobes the outputs hold their values, so the data-phase logic downstream can read a stable target. When the select field is malformed, no device is selected and an error flag is raised. A diagnostic index then gives the position of the highest set bit anywhere in the address, to help locate a stray bit.

Top module: `cfg_sel_decode`

## Requirements
- R1: While reset is applied and until the first strobed capture, every output is zero.
- R2: `tgt_valid` is 1 after a capture exactly when address bits 31:11 contain exactly one set bit; any other count (zero, two or more) gives 0.
- R3: On a valid capture `tgt_dev` equals the bit position (11 to 31) of the single set select bit; on an invalid capture `tgt_dev` is 0.
- R4: Every capture sets `tgt_type0` to 1 and drives `tgt_bus` to 0.
- R5: `tgt_err` after a capture is the inverse of `tgt_valid`.
- R6: On an invalid capture `diag_idx` holds the position of the highest set bit of the full 32-bit address, or 63 (all ones, meaning minus one) when the address is zero; on a valid capture it is 0.
- R7: After any capture `tgt_fn` equals address bits 10:8, and `tgt_reg` equals address bits 7:2 in its bits 7:2, with bits 1:0 zero.
- R8: Outputs change only on a rising clock edge where `acc_stb` is 1; on all other edges they keep their values whatever the address input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_stb | input | 1 | Configuration access strobe; captures the decode |
| cfg_addr | input | 32 | Latched configuration address |
| tgt_valid | output | 1 | Select field holds exactly one set bit |
| tgt_err | output | 1 | Malformed select field |
| tgt_type0 | output | 1 | Captured access is a first-level configuration cycle |
| tgt_bus | output | 8 | Bus number, always zero |
| tgt_dev | output | 5 | Device number (select bit position) |
| tgt_fn | output | 3 | Function number |
| tgt_reg | output | 8 | Dword-aligned register offset |
| diag_idx | output | 6 | Highest set address bit on error, 63 for a zero address |

## Verification
The assertions assume that `acc_stb` and `cfg_addr` are known and steady around each rising edge. They also assume the strobe is low while reset is active, because several properties compare the outputs with the address sampled one edge earlier. The bench changes inputs only on falling edges and holds the strobe low through reset. Between strobes it moves the address to new values, so the hold property is exercised by real input activity and not by an idle bus.

// File: rtl/cfg_sel_pkg.sv
package cfg_sel_pkg;
  localparam int unsigned CS_ADDR_W  = 32;
  localparam int unsigned CS_SEL_LSB = 11;
  localparam int unsigned CS_FN_LSB  = 8;
  localparam int unsigned CS_FN_W    = 3;
  localparam int unsigned CS_REG_W   = 8;
  localparam int unsigned CS_BUS_W   = 8;
endpackage

// File: rtl/cfg_sel_rst_sync.sv
module cfg_sel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/cfg_sel_onehot.sv
module cfg_sel_onehot #(
  parameter int unsigned SEL_W   = 21,
  parameter int unsigned SEL_LSB = 11,
  parameter int unsigned POS_W   = 5
) (
  input  logic [SEL_W-1:0] sel,
  output logic             hit,
  output logic [POS_W-1:0] pos
);
  logic [SEL_W-1:0] low_clear;

  // Clearing the lowest set bit leaves zero only for a single-bit pattern.
  assign low_clear = sel & (sel - SEL_W'(1));
  assign hit       = (sel != '0) && (low_clear == '0);

  // OR-encoder: correct only when hit is true; the result is masked otherwise.
  always_comb begin
    pos = '0;
    for (int i = 0; i < int'(SEL_W); i++) begin
      if (sel[i]) pos = pos | POS_W'(i + int'(SEL_LSB));
    end
  end
endmodule

// File: rtl/cfg_sel_msb.sv
module cfg_sel_msb #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  // All ones stands for minus one: an all-zero address has no set bit.
  always_comb begin
    idx = '1;
    for (int i = 0; i < int'(ADDR_W); i++) begin
      if (addr[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/cfg_sel_decode.sv
module cfg_sel_decode
  import cfg_sel_pkg::*;
#(
  parameter int unsigned ADDR_W  = CS_ADDR_W,
  parameter int unsigned SEL_LSB = CS_SEL_LSB,
  parameter int unsigned FN_LSB  = CS_FN_LSB,
  parameter int unsigned FN_W    = CS_FN_W,
  parameter int unsigned REG_W   = CS_REG_W,
  parameter int unsigned BUS_W   = CS_BUS_W,
  localparam int unsigned DEV_W  = $clog2(ADDR_W),
  localparam int unsigned DIAG_W = DEV_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic              tgt_valid,
  output logic              tgt_err,
  output logic              tgt_type0,
  output logic [BUS_W-1:0]  tgt_bus,
  output logic [DEV_W-1:0]  tgt_dev,
  output logic [FN_W-1:0]   tgt_fn,
  output logic [REG_W-1:0]  tgt_reg,
  output logic [DIAG_W-1:0] diag_idx
);
  localparam int unsigned SEL_W = ADDR_W - SEL_LSB;

  logic              rst_n_s;
  logic              sel_hit;
  logic [DEV_W-1:0]  sel_pos;
  logic [DIAG_W-1:0] msb_idx;

  logic              valid_d, err_d, type0_d;
  logic [BUS_W-1:0]  bus_d;
  logic [DEV_W-1:0]  dev_d;
  logic [FN_W-1:0]   fn_d;
  logic [REG_W-1:0]  reg_d;
  logic [DIAG_W-1:0] diag_d;

  cfg_sel_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cfg_sel_onehot #(
    .SEL_W   (SEL_W),
    .SEL_LSB (SEL_LSB),
    .POS_W   (DEV_W)
  ) u_onehot (
    .sel (cfg_addr[ADDR_W-1:SEL_LSB]),
    .hit (sel_hit),
    .pos (sel_pos)
  );

  cfg_sel_msb #(
    .ADDR_W (ADDR_W),
    .IDX_W  (DIAG_W)
  ) u_msb (
    .addr (cfg_addr),
    .idx  (msb_idx)
  );

  // Next-state decode
  always_comb begin
    valid_d = sel_hit;
    err_d   = !sel_hit;
    type0_d = 1'b1;
    bus_d   = '0;
    dev_d   = sel_hit ? sel_pos : '0;
    diag_d  = sel_hit ? '0 : msb_idx;
    fn_d    = cfg_addr[FN_LSB +: FN_W];
    reg_d   = {cfg_addr[REG_W-1:2], 2'b00};
  end

  // Output registers, enabled by the access strobe
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      tgt_valid <= 1'b0;
      tgt_err   <= 1'b0;
      tgt_type0 <= 1'b0;
      tgt_bus   <= '0;
      tgt_dev   <= '0;
      tgt_fn    <= '0;
      tgt_reg   <= '0;
      diag_idx  <= '0;
    end else if (acc_stb) begin
      tgt_valid <= valid_d;
      tgt_err   <= err_d;
      tgt_type0 <= type0_d;
      tgt_bus   <= bus_d;
      tgt_dev   <= dev_d;
      tgt_fn    <= fn_d;
      tgt_reg   <= reg_d;
      diag_idx  <= diag_d;
    end
  end

  // R2: a valid capture came from a single-bit select field
  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(acc_stb) && tgt_valid) |-> ($countones($past(cfg_addr[ADDR_W-1:SEL_LSB])) == 1));

  // R3: the reported device bit was set in the captured address
  p_dev_bit_set_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(acc_stb) && tgt_valid) |-> ((($past(cfg_addr) >> tgt_dev) & ADDR_W'(1)) == ADDR_W'(1)));

  // R4: captured accesses are first-level cycles on bus zero
  p_type0_bus0_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(acc_stb) |-> (tgt_type0 && (tgt_bus == '0)));

  // R5: an error capture selects no device
  p_err_no_dev_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    tgt_err |-> (!tgt_valid && (tgt_dev == '0)));

  // R8: without a strobe nothing moves
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !acc_stb |=> ($stable(tgt_valid) && $stable(tgt_err) && $stable(tgt_dev) &&
                  $stable(tgt_fn) && $stable(tgt_reg) && $stable(diag_idx) &&
                  $stable(tgt_type0)));
endmodule

// File: tb/cfg_sel_decode_tb_top.sv
module cfg_sel_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_stb = 1'b0;
  logic [31:0] cfg_addr = '0;
  logic        tgt_valid, tgt_err, tgt_type0;
  logic [7:0]  tgt_bus;
  logic [4:0]  tgt_dev;
  logic [2:0]  tgt_fn;
  logic [7:0]  tgt_reg;
  logic [5:0]  diag_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_sel_decode dut_i (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .cfg_addr(cfg_addr),
    .tgt_valid(tgt_valid), .tgt_err(tgt_err), .tgt_type0(tgt_type0),
    .tgt_bus(tgt_bus), .tgt_dev(tgt_dev), .tgt_fn(tgt_fn),
    .tgt_reg(tgt_reg), .diag_idx(diag_idx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input logic [31:0] addr);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%08h actual=%0h expected=%0h", req, addr, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a);
    int ones;
    int pos;
    int top;
    bit v;
    @(negedge clk);
    acc_stb  = 1'b1;
    cfg_addr = a;
    @(negedge clk);
    acc_stb  = 1'b0;
    ones = 0; pos = 0; top = 63;
    for (int i = 0; i < 32; i++) begin
      if (a[i]) top = i;
      if (i >= 11 && a[i]) begin ones++; pos = i; end
    end
    v = (ones == 1);
    check("R2 valid", 32'(tgt_valid), 32'(v), a);
    check("R3 dev", 32'(tgt_dev), v ? 32'(pos) : 32'd0, a);
    check("R4 type0/bus", {23'd0, tgt_type0, tgt_bus}, 32'h100, a);
    check("R5 err", 32'(tgt_err), 32'(!v), a);
    check("R6 diag", 32'(diag_idx), v ? 32'd0 : 32'(top), a);
    check("R7 fn", 32'(tgt_fn), 32'((a >> 8) & 7), a);
    check("R7 reg", 32'(tgt_reg), a & 32'hFC, a);
  endtask

  task automatic hold_test(input logic [31:0] a);
    logic [31:0] snap;
    snap = {tgt_valid, tgt_err, tgt_type0, tgt_dev, tgt_fn, tgt_reg, diag_idx, 7'd0};
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    @(negedge clk);
    check("R8 hold", {tgt_valid, tgt_err, tgt_type0, tgt_dev, tgt_fn, tgt_reg, diag_idx, 7'd0},
          snap, a);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, checked during reset and after release before any strobe
    check("R1 reset", {tgt_valid, tgt_err, tgt_type0, tgt_bus, tgt_dev, tgt_fn, tgt_reg, diag_idx},
          32'd0, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle", {tgt_valid, tgt_err, tgt_type0, tgt_bus, tgt_dev, tgt_fn, tgt_reg, diag_idx},
          32'd0, 32'd0);

    // Zero address: diag reports minus one
    access(32'h0000_0000);
    // Every single bit, including low-only addresses
    for (int b = 0; b < 32; b++) access(32'd1 << b);
    // All pairs of select bits
    for (int i = 11; i < 32; i++)
      for (int j = i + 1; j < 32; j++) access((32'd1 << i) | (32'd1 << j));
    // Full sweep of the function/register field under one select bit
    for (int k = 0; k < 2048; k++) access(32'h0010_0000 | 32'(k));
    // Low field sweep with no select bit
    for (int k = 0; k < 2048; k += 37) access(32'(k));
    // Dense select fields
    access(32'hFFFF_F800);
    access(32'hFFFF_FFFF);
    access(32'h8000_07FF);

    // R8: address moves without strobe, outputs hold
    access(32'h0000_1A5C);
    hold_test(32'hFFFF_FFFF);
    access(32'hC000_0000);
    hold_test(32'h0400_0304);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule